// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Decoder

This block listens to the two open-collector lines of a PS/2 keyboard, the device-driven clock and the data, and turns their traffic into whole key events. Both lines are first brought into the system clock domain and cleaned of short spikes. A receiver then collects each 11-bit device-to-host word on the falling edges of the keyboard clock and checks its framing and its parity.

The receiver's bytes go to a small tracker that consumes the two prefix bytes. The prefix `E0` marks an extended key and `F0` marks a key release. The tracker emits one event per key action: the scan code, a break (release) flag and an extended flag, all qualified by a one-cycle strobe. A corrupt word raises a one-cycle error pulse instead. Typical use is behind a keyboard port. A later stage maps the events to characters or key state; that mapping is not part of this block.

Top module: `ps2_key_decoder`

## Requirements
- R1: A word is one start bit (0), eight data bits with the least significant bit first, one parity bit that makes the count of ones over data and parity odd, and one stop bit (1). Each bit is taken on a falling edge of the filtered keyboard clock.
- R2: A correct word whose byte is neither `E0` nor `F0` produces exactly one `key_valid` pulse of one cycle, with `key_code` equal to the byte and `key_break` = 0 and `key_ext` = 0 when no prefix came before it.
- R3: The byte `F0` followed by a code byte produces one event with `key_break` = 1 and `key_code` equal to the code byte.
- R4: The byte `E0` sets `key_ext` = 1 on the next event. The sequence `E0`, `F0`, code produces one event with `key_ext` = 1 and `key_break` = 1.
- R5: The prefix bytes `E0` and `F0` produce no event of their own.
- R6: The same code byte sent several times in a row produces a new press event for every copy.
- R7: A word with wrong parity or a stop bit of 0 produces a one-cycle `rx_error` pulse and no event. It also clears any pending `E0`/`F0` prefix, so the next code is reported as a plain press. `key_valid` and `rx_error` are never high in the same cycle.
- R8: When the clock is pulled low while data is high and no word is in progress (the host inhibiting the keyboard), nothing is received: no event and no error.
- R9: If no falling clock edge arrives for `TIMEOUT_CYC` system cycles during a word, the partial word is dropped without an error. The next full word is then decoded normally.
- R10: A level change on either line that lasts fewer than `FILT_LEN` system cycles does not reach the receiver.
- R11: After reset, `key_valid` and `rx_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Keyboard clock line, asynchronous, idles high |
| ps2_dat_in | input | 1 | Keyboard data line, asynchronous, idles high |
| key_valid | output | 1 | One-cycle strobe: a key event is present |
| key_code | output | 8 | Scan code of the event |
| key_break | output | 1 | 1 for a key release, 0 for a press |
| key_ext | output | 1 | 1 when the code came after the extended prefix |
| rx_error | output | 1 | One-cycle pulse on a parity or stop-bit failure |

## Verification
The bench targets prefix handling. One case is an error word placed between `E0` and its code. A tracker that kept the prefix across the error would report that code as extended. A second case is the double prefix `E0 F0` on a release: a tracker that cleared `E0` when it saw `F0` would report the release as a non-extended key. Host inhibit and a word abandoned halfway are also covered. A receiver that treated the inhibit as a start bit, or never timed out, would misalign the next word and report a wrong code or a false error. The bench also sends a two-cycle spike on the clock line. A filter that passed it would start a phantom word.

// File: rtl/ps2kd_pkg.sv
package ps2kd_pkg;

    localparam logic [7:0] CODE_EXT_PREFIX = 8'hE0;
    localparam logic [7:0] CODE_BRK_PREFIX = 8'hF0;
    localparam int         WORD_BITS       = 10; // bits after the start bit

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_t;

    typedef struct packed {
        logic [7:0] code;
        logic       is_break;
        logic       is_ext;
    } key_event_t;

    // data plus parity must hold an odd number of ones
    function automatic logic parity_good(input logic [8:0] data_and_par);
        return ^data_and_par;
    endfunction

    function automatic logic is_prefix(input logic [7:0] b);
        return (b == CODE_EXT_PREFIX) || (b == CODE_BRK_PREFIX);
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '1;
            run_cnt   <= '0;
            clean_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            if (synced == clean_out) begin
                run_cnt <= '0;
            end else if (run_cnt == CNT_LAST) begin
                clean_out <= synced;
                run_cnt   <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean_out) |-> $past(run_cnt) == CNT_LAST) else $error("filter moved early"); // R10

endmodule

// File: rtl/ps2_word_rx.sv
module ps2_word_rx
    import ps2kd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_clk,
    input  logic       line_dat,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC);
    localparam int BCW = $clog2(WORD_BITS);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(WORD_BITS - 1);

    rx_state_t               state;
    logic                    clk_prev;
    logic                    fall;
    logic [BCW-1:0]          bit_idx;
    logic [WORD_BITS-1:0]    shreg;
    logic [WORD_BITS-1:0]    word_next;
    logic [TW-1:0]           quiet_cnt;

    assign fall      = clk_prev & ~line_clk;
    assign word_next = {line_dat, shreg[WORD_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            clk_prev   <= 1'b1;
            bit_idx    <= '0;
            shreg      <= '0;
            quiet_cnt  <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_err  <= 1'b0;
        end else begin
            clk_prev   <= line_clk;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    quiet_cnt <= '0;
                    bit_idx   <= '0;
                    // a falling clock with data high is host inhibit, not a start
                    if (fall && !line_dat) state <= RX_BUSY;
                end
                RX_BUSY: begin
                    if (fall) begin
                        quiet_cnt <= '0;
                        shreg     <= word_next;
                        if (bit_idx == BIT_LAST) begin
                            state <= RX_IDLE;
                            if (word_next[9] && parity_good(word_next[8:0])) begin
                                byte_valid <= 1'b1;
                                byte_data  <= word_next[7:0];
                            end else begin
                                frame_err <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else if (quiet_cnt == T_LAST) begin
                        state <= RX_IDLE;
                    end else begin
                        quiet_cnt <= quiet_cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= BIT_LAST) else $error("bit index overran"); // R1

    AST_QUIET_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state == RX_BUSY && !fall && quiet_cnt == T_LAST) |=> state == RX_IDLE) else $error("no timeout"); // R9

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frame_err)) else $error("byte and error together"); // R7

endmodule

// File: rtl/ps2_event_track.sv
module ps2_event_track
    import ps2kd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       frame_err,
    output logic       ev_valid,
    output key_event_t ev,
    output logic       err_pulse
);
    logic ext_pend;
    logic brk_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend  <= 1'b0;
            brk_pend  <= 1'b0;
            ev_valid  <= 1'b0;
            ev        <= '0;
            err_pulse <= 1'b0;
        end else begin
            ev_valid  <= 1'b0;
            err_pulse <= 1'b0;
            if (frame_err) begin
                err_pulse <= 1'b1;
                ext_pend  <= 1'b0;
                brk_pend  <= 1'b0;
            end else if (byte_valid) begin
                if (byte_data == CODE_EXT_PREFIX) begin
                    ext_pend <= 1'b1;
                end else if (byte_data == CODE_BRK_PREFIX) begin
                    brk_pend <= 1'b1;
                end else begin
                    ev_valid    <= 1'b1;
                    ev.code     <= byte_data;
                    ev.is_break <= brk_pend;
                    ev.is_ext   <= ext_pend;
                    ext_pend    <= 1'b0;
                    brk_pend    <= 1'b0;
                end
            end
        end
    end

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && is_prefix(byte_data)) |=> !ev_valid) else $error("prefix emitted event"); // R5

    AST_ERR_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> (err_pulse && !ev_valid)) else $error("error word handled wrong"); // R7

    AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> !ev_valid) else $error("event strobe stretched"); // R2

endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder
    import ps2kd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       key_valid,
    output logic [7:0] key_code,
    output logic       key_break,
    output logic       key_ext,
    output logic       rx_error
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic                 rx_byte_valid;
    logic [7:0]           rx_byte;
    logic                 rx_frame_err;
    key_event_t           ev;

    assign raw_lines = {ps2_dat_in, ps2_clk_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        ps2_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (raw_lines[g]),
            .clean_out(clean_lines[g])
        );
    end

    ps2_word_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .line_clk  (clean_lines[0]),
        .line_dat  (clean_lines[1]),
        .byte_valid(rx_byte_valid),
        .byte_data (rx_byte),
        .frame_err (rx_frame_err)
    );

    ps2_event_track u_track (
        .clk       (clk),
        .rst       (rst),
        .byte_valid(rx_byte_valid),
        .byte_data (rx_byte),
        .frame_err (rx_frame_err),
        .ev_valid  (key_valid),
        .ev        (ev),
        .err_pulse (rx_error)
    );

    assign key_code  = ev.code;
    assign key_break = ev.is_break;
    assign key_ext   = ev.is_ext;

    AST_VALID_XOR_ERROR: assert property (@(posedge clk) disable iff (rst)
        !(key_valid && rx_error)) else $error("event and error together"); // R7

    AST_ERROR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_error |=> !rx_error) else $error("error pulse stretched"); // R7

endmodule

// File: tb/tb_ps2_key_decoder.sv
module tb_ps2_key_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 40;
    localparam int FILT       = 4;
    localparam int TMO        = 300;
    localparam int SETTLE     = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       key_valid;
    logic [7:0] key_code;
    logic       key_break;
    logic       key_ext;
    logic       rx_error;

    int checks = 0;
    int failures = 0;
    int ev_total = 0;
    int err_total = 0;
    logic [7:0] last_code = '0;
    logic       last_brk = 1'b0;
    logic       last_ext = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_key_decoder #(.SYNC_STAGES(2), .FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .ps2_clk_in(kclk), .ps2_dat_in(kdat),
        .key_valid(key_valid), .key_code(key_code), .key_break(key_break),
        .key_ext(key_ext), .rx_error(rx_error)
    );

    always @(negedge clk) begin
        if (!rst && key_valid) begin
            ev_total  <= ev_total + 1;
            last_code <= key_code;
            last_brk  <= key_break;
            last_ext  <= key_ext;
        end
        if (!rst && rx_error) err_total <= err_total + 1;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        kdat = b;
        wait_cyc(HALF_BIT);
        kclk = 1'b0;
        wait_cyc(HALF_BIT);
        kclk = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit((~^b) ^ bad_par);
        send_bit(!bad_stop);
        kdat = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic expect_event(input string req, input int ev0, input int err0,
                                input logic [7:0] code, input logic brk, input logic ext);
        chk(req, ev_total == ev0 + 1, ev_total - ev0, 1);
        chk(req, err_total == err0, err_total - err0, 0);
        chk(req, {last_code, last_brk, last_ext} == {code, brk, ext},
            {last_code, last_brk, last_ext}, {code, brk, ext});
    endtask

    task automatic t_reset;
        chk("R11", key_valid == 1'b0, key_valid, 0);
        chk("R11", rx_error == 1'b0, rx_error, 0);
    endtask

    task automatic t_press;
        int e0 = ev_total, r0 = err_total;
        send_word(8'h1C, 0, 0);
        expect_event("R1 R2", e0, r0, 8'h1C, 1'b0, 1'b0);
    endtask

    task automatic t_release;
        int e0 = ev_total, r0 = err_total;
        send_word(8'hF0, 0, 0);
        chk("R5", ev_total == e0, ev_total - e0, 0);
        send_word(8'h1C, 0, 0);
        expect_event("R3", e0, r0, 8'h1C, 1'b1, 1'b0);
    endtask

    task automatic t_extended;
        int e0 = ev_total, r0 = err_total;
        send_word(8'hE0, 0, 0);
        chk("R5", ev_total == e0, ev_total - e0, 0);
        send_word(8'h75, 0, 0);
        expect_event("R4 press", e0, r0, 8'h75, 1'b0, 1'b1);
        e0 = ev_total;
        send_word(8'hE0, 0, 0);
        send_word(8'hF0, 0, 0);
        chk("R5", ev_total == e0, ev_total - e0, 0);
        send_word(8'h75, 0, 0);
        expect_event("R4 release", e0, r0, 8'h75, 1'b1, 1'b1);
    endtask

    task automatic t_repeat;
        int e0 = ev_total;
        for (int k = 0; k < 3; k++) send_word(8'h23, 0, 0);
        chk("R6", ev_total == e0 + 3, ev_total - e0, 3);
        chk("R6", {last_code, last_brk} == {8'h23, 1'b0}, {last_code, last_brk}, {8'h23, 1'b0});
    endtask

    task automatic t_errors;
        int e0 = ev_total, r0 = err_total;
        send_word(8'h2A, 1, 0);
        chk("R7 parity", err_total == r0 + 1, err_total - r0, 1);
        chk("R7 parity", ev_total == e0, ev_total - e0, 0);
        e0 = ev_total; r0 = err_total;
        send_word(8'hE0, 0, 0);
        send_word(8'h75, 0, 1);
        chk("R7 stop", err_total == r0 + 1, err_total - r0, 1);
        r0 = err_total;
        send_word(8'h75, 0, 0);
        expect_event("R7 prefix cleared", e0, r0, 8'h75, 1'b0, 1'b0);
    endtask

    task automatic t_inhibit;
        int e0 = ev_total, r0 = err_total;
        kdat = 1'b1;
        kclk = 1'b0;
        wait_cyc(2000);
        kclk = 1'b1;
        wait_cyc(SETTLE);
        chk("R8", ev_total == e0, ev_total - e0, 0);
        chk("R8", err_total == r0, err_total - r0, 0);
        send_word(8'h5A, 0, 0);
        expect_event("R8 after", e0, r0, 8'h5A, 1'b0, 1'b0);
    endtask

    task automatic t_timeout;
        int e0 = ev_total, r0 = err_total;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        kdat = 1'b1;
        wait_cyc(2 * TMO);
        chk("R9", err_total == r0, err_total - r0, 0);
        send_word(8'h34, 0, 0);
        expect_event("R9", e0, r0, 8'h34, 1'b0, 1'b0);
    endtask

    task automatic t_glitch;
        int e0 = ev_total, r0 = err_total;
        kdat = 1'b0;
        wait_cyc(10);
        kclk = 1'b0;
        wait_cyc(FILT - 2);
        kclk = 1'b1;
        wait_cyc(10);
        kdat = 1'b1;
        wait_cyc(SETTLE);
        send_word(8'h4D, 0, 0);
        expect_event("R10", e0, r0, 8'h4D, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_press();
        t_release();
        t_extended();
        t_repeat();
        t_errors();
        t_inhibit();
        t_timeout();
        t_glitch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule